// File: doc/BRIEF.md
# Noise-Tolerant Single-Wire Slot-Start Detector

This block sits on the slave side of a single-wire, open-drain serial line. It reports the start of each bit time slot. The analog front end provides two digitized comparator outputs:

- one that is high while the line is above the upper switching threshold;
- one that is high while the line is above a lower threshold set one hysteresis step below the upper one.

From these two inputs the block produces a filtered line level and a one-cycle slot-start pulse. Downstream bit decoding uses the pulse to time its sampling and its response.

Three mechanisms keep ringing and coupled noise from being taken as a slot start:

- **Falling-edge filter.** A falling edge counts only when the lower-threshold input has stayed low for a programmable run of clock cycles.
- **Hysteresis.** The filtered level falls only through the lower-threshold input and rises only through the upper-threshold input.
- **Hold-off window.** After every filtered rise, a programmable number of cycles follows during which even deep dips are ignored. A droop that is still present, or that arrives after the window closes, is accepted as a new slot.

Both comparator inputs pass through a two-stage synchronizer before use. The filter length and the hold-off length are static configuration inputs, counted in clock cycles.

Top module: `owire_slot_detect`

## Requirements
- R1: After reset, `line_o` is 1 and `slot_start_o` is 0.
- R2: While `line_o` is 1 and no hold-off is running, the falling edge is accepted once `cmp_lo_i` has been 0 for L consecutive cycles, where L = max(`filt_len_i`, 1). The accepted edge is taken on the L-th cycle. `slot_start_o` is high in the cycle after the (L+2)-th rising clock edge that follows the change of `cmp_lo_i`, and `line_o` falls in the same cycle.
- R3: A low run on `cmp_lo_i` shorter than L cycles produces no pulse and leaves `line_o` at 1. Any high cycle on `cmp_lo_i` restarts the count.
- R4: A dip of `cmp_hi_i` to 0 while `cmp_lo_i` stays 1 is never a falling edge, however long it lasts.
- R5: While `line_o` is 0, `cmp_lo_i` = 1 with `cmp_hi_i` = 0 keeps `line_o` at 0.
- R6: `line_o` rises to 1 in the cycle after the 3rd rising clock edge that follows `cmp_hi_i` going to 1.
- R7: Each rise of `line_o` starts a hold-off of `holdoff_i` cycles. Low values on `cmp_lo_i` seen in that window are not counted and cause no pulse.
- R8: A low on `cmp_lo_i` that persists past the end of the hold-off, or starts after it, is accepted. Counting begins at the first cycle after the window, so the pulse follows the line's rise (`cmp_hi_i` going to 1) by `holdoff_i` + L + 3 edges.
- R9: `slot_start_o` is exactly one cycle wide and fires once per accepted falling edge. A line held low does not repeat it.
- R10: With `holdoff_i` = 0 there is no hold-off, and a low directly after a rise is filtered as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi_i | input | 1 | 1 while line is above the upper threshold (asynchronous) |
| cmp_lo_i | input | 1 | 1 while line is above the lower threshold (asynchronous) |
| filt_len_i | input | FILT_W | Falling-edge filter length in cycles (0 acts as 1) |
| holdoff_i | input | HOLD_W | Hold-off window length in cycles after each rise |
| slot_start_o | output | 1 | One-cycle pulse per accepted slot start |
| line_o | output | 1 | Filtered line level |

## Verification
A run counter that is not cleared by a high cycle would show up as a pulse after split low runs. A miscounted filter would move the pulse edge by one or more cycles against the L+2 latency, and edge-exact sampling detects that within the first slot.

A hold-off that is never loaded, or that expires early, produces a pulse from a glitch inside the window within a few cycles of the glitch. A hold-off that never ends suppresses the late droop, and the expected pulse goes missing a fixed number of edges after the rise.

A swapped comparator in either direction moves `line_o` during the hysteresis scenarios. Such a change is visible within three cycles of the offending input.

// File: rtl/owsd_pkg.sv
package owsd_pkg;

    // Effective filter length: a zero setting behaves as one cycle.
    function automatic int unsigned eff_len(input int unsigned setting);
        return (setting == 0) ? 1 : setting;
    endfunction

endpackage

// File: rtl/owsd_sync.sv
module owsd_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic        RST_V  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= {WIDTH{RST_V}};
            end else if (s == 0) begin
                stage_q[s] <= async_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/owsd_core.sv
module owsd_core #(
    parameter int unsigned FILT_W = 6,
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_i,
    input  logic              lo_i,
    input  logic [FILT_W-1:0] filt_len_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              level_o,
    output logic              pulse_o,
    output logic              hold_busy_o
);
    localparam int unsigned CW = FILT_W + 1;

    typedef struct packed {
        logic              level;
        logic              pulse;
        logic [FILT_W-1:0] run;
        logic [HOLD_W-1:0] hold;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [CW-1:0] need;
    logic [CW-1:0] run_nx;

    always_comb begin
        need   = CW'(owsd_pkg::eff_len(int'(filt_len_i)));
        run_nx = {1'b0, st_q.run} + CW'(1);
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - HOLD_W'(1);
        end
        if (st_q.level) begin
            if (!lo_i && (st_q.hold == '0)) begin
                if (run_nx >= need) begin
                    st_d.level = 1'b0;
                    st_d.pulse = 1'b1;
                    st_d.run   = '0;
                end else begin
                    st_d.run = run_nx[FILT_W-1:0];
                end
            end else begin
                st_d.run = '0;
            end
        end else begin
            st_d.run = '0;
            if (hi_i) begin
                st_d.level = 1'b1;
                st_d.hold  = holdoff_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{level: 1'b1, pulse: 1'b0, run: '0, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o     = st_q.level;
    assign pulse_o     = st_q.pulse;
    assign hold_busy_o = (st_q.hold != '0);
endmodule

// File: rtl/owire_slot_detect.sv
module owire_slot_detect #(
    parameter int unsigned FILT_W = 6,
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_hi_i,
    input  logic              cmp_lo_i,
    input  logic [FILT_W-1:0] filt_len_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              slot_start_o,
    output logic              line_o
);
    logic [1:0] cmp_s;
    logic       hi_s;
    logic       lo_s;
    logic       hold_busy;

    owsd_sync #(.WIDTH(2), .STAGES(2), .RST_V(1'b1)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cmp_hi_i, cmp_lo_i}),
        .sync_o  (cmp_s)
    );

    assign hi_s = cmp_s[1];
    assign lo_s = cmp_s[0];

    owsd_core #(.FILT_W(FILT_W), .HOLD_W(HOLD_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hi_i        (hi_s),
        .lo_i        (lo_s),
        .filt_len_i  (filt_len_i),
        .holdoff_i   (holdoff_i),
        .level_o     (line_o),
        .pulse_o     (slot_start_o),
        .hold_busy_o (hold_busy)
    );
endmodule

// File: rtl/owsd_checker.sv
module owsd_checker (
    input logic clk,
    input logic rst_n,
    input logic slot_start,
    input logic line,
    input logic hi_s,
    input logic lo_s,
    input logic hold_busy
);
    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> !slot_start);

    // R9
    pulse_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> $fell(line));

    // R2
    fall_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line) |-> slot_start);

    // R4
    fall_from_low_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line) |-> !$past(lo_s));

    // R5
    rise_from_high_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line) |-> $past(hi_s));

    // R7
    holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |-> !$past(hold_busy));
endmodule

bind owire_slot_detect owsd_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start_o),
    .line       (line_o),
    .hi_s       (hi_s),
    .lo_s       (lo_s),
    .hold_busy  (hold_busy)
);

// File: tb/owire_slot_detect_tb_top.sv
`timescale 1ns/1ps
module owire_slot_detect_tb_top;
    localparam int FW = 6;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_hi = 1'b1;
    logic          cmp_lo = 1'b1;
    logic [FW-1:0] filt_len = FW'(3);
    logic [HW-1:0] holdoff = '0;
    logic          slot_start_o;
    logic          line_o;

    int n_cmp = 0;
    int n_bad = 0;
    int edge_n = 0;
    int pulse_cnt = 0;
    int last_pulse_edge = -1;
    bit finished = 0;

    always #10 clk = ~clk;

    owire_slot_detect #(.FILT_W(FW), .HOLD_W(HW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_hi_i     (cmp_hi),
        .cmp_lo_i     (cmp_lo),
        .filt_len_i   (filt_len),
        .holdoff_i    (holdoff),
        .slot_start_o (slot_start_o),
        .line_o       (line_o)
    );

    always @(posedge clk) edge_n <= edge_n + 1;

    always @(negedge clk) begin
        if (rst_n && slot_start_o) begin
            pulse_cnt++;
            last_pulse_edge = edge_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic hi, input logic lo);
        @(negedge clk);
        cmp_hi = hi;
        cmp_lo = lo;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_high();
        drive(1'b1, 1'b1);
        idle(holdoff + 8);
    endtask

    task automatic t_reset();
        check("R1 line", int'(line_o), 1);
        check("R1 pulse", int'(slot_start_o), 0);
    endtask

    task automatic t_filter_exact(input int n);
        int p0;
        int e;
        int l;
        l = (n == 0) ? 1 : n;
        filt_len = FW'(n);
        holdoff = '0;
        go_high();
        p0 = pulse_cnt;
        drive(1'b0, 1'b0);
        e = edge_n;
        idle(l + 6);
        check("R2 count", pulse_cnt - p0, 1);
        check("R2 edge", last_pulse_edge, e + l + 2);
        check("R2 line", int'(line_o), 0);
        idle(40);
        check("R9 once", pulse_cnt - p0, 1);
    endtask

    task automatic t_filter_short(input int n);
        int p0;
        filt_len = FW'(n);
        holdoff = '0;
        go_high();
        p0 = pulse_cnt;
        drive(1'b0, 1'b0);
        idle(n - 2);
        drive(1'b1, 1'b1);
        idle(3);
        drive(1'b0, 1'b0);
        idle(n - 2);
        drive(1'b1, 1'b1);
        idle(10);
        check("R3 pulses", pulse_cnt - p0, 0);
        check("R3 line", int'(line_o), 1);
    endtask

    task automatic t_hyst_fall();
        int p0;
        filt_len = FW'(2);
        holdoff = '0;
        go_high();
        p0 = pulse_cnt;
        drive(1'b0, 1'b1);
        idle(40);
        check("R4 pulses", pulse_cnt - p0, 0);
        check("R4 line", int'(line_o), 1);
        drive(1'b1, 1'b1);
    endtask

    task automatic t_hyst_rise();
        filt_len = FW'(2);
        holdoff = '0;
        go_high();
        drive(1'b0, 1'b0);
        idle(10);
        drive(1'b0, 1'b1);
        idle(30);
        check("R5 line", int'(line_o), 0);
        drive(1'b1, 1'b1);
        idle(2);
        check("R6 early", int'(line_o), 0);
        idle(1);
        check("R6 rise", int'(line_o), 1);
    endtask

    task automatic t_holdoff();
        int p0;
        int e2;
        filt_len = FW'(3);
        holdoff = HW'(20);
        go_high();
        drive(1'b0, 1'b0);
        idle(10);
        p0 = pulse_cnt;
        drive(1'b1, 1'b1);
        idle(4);
        drive(1'b0, 1'b0);
        idle(6);
        drive(1'b1, 1'b1);
        idle(30);
        check("R7 pulses", pulse_cnt - p0, 0);
        check("R7 line", int'(line_o), 1);
        drive(1'b0, 1'b0);
        idle(10);
        check("R8 late", pulse_cnt - p0, 1);
        drive(1'b1, 1'b1);
        e2 = edge_n;
        idle(7);
        drive(1'b0, 1'b0);
        idle(40);
        check("R8 straddle", pulse_cnt - p0, 2);
        check("R8 edge", last_pulse_edge, e2 + 20 + 3 + 3);
    endtask

    task automatic t_nohold();
        int p0;
        int e;
        filt_len = FW'(2);
        holdoff = '0;
        go_high();
        drive(1'b0, 1'b0);
        idle(10);
        p0 = pulse_cnt;
        drive(1'b1, 1'b1);
        drive(1'b0, 1'b0);
        e = edge_n;
        idle(10);
        check("R10 count", pulse_cnt - p0, 1);
        check("R10 edge", last_pulse_edge, e + 2 + 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_filter_exact(1);
        t_filter_exact(4);
        t_filter_exact(0);
        t_filter_short(5);
        t_hyst_fall();
        t_hyst_rise();
        t_holdoff();
        t_nohold();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule